// File: doc/BRIEF.md
# Power-Management Event Window with System Control Interrupt

This block is the power-management register window of a south bridge. It holds the event status, event enable and control registers and a free-running power-management timer. From them it drives one level-sensitive system control interrupt line (`sci`). Three external event inputs (clock alarm, power button, global lock release) and the timer's overflow set the status bits. Software clears a status bit by writing a one to it.

The window is 64 bytes long and lives in I/O space. Its base address comes from a 32-bit configuration value masked with 0xFFC0. Its decode enable comes from bit 0 of a configuration control byte. A three-state window machine governs access. `WIN_OFF` ignores every access. `WIN_IDLE` accepts writes and read requests. `WIN_RDATA` presents read data for one cycle. The transitions are:

- any state goes to `WIN_OFF` when the enable bit is low;
- with the enable bit high, a state goes to `WIN_RDATA` on a read that hits the window;
- otherwise it goes to `WIN_IDLE`.

Top module: `pm1_sci_top`

## Requirements
- R1: After reset the window is in `WIN_OFF`, and `sci` and `io_rvalid` are 0. The status, enable and control registers and the timer all read 0 once the window is enabled.
- R2: The window decodes an address when `io_addr & 0xFFC0` equals `cfg_pm_base & 0xFFC0` and the state is not `WIN_OFF`. The state leaves `WIN_OFF` the cycle after `cfg_pm_ctrl[0]` is seen high. Accesses outside the window, or made while it is off, give no `io_rvalid` and change no register.
- R3: A read that hits the window gives `io_rvalid` high, with the data on `io_rdata`, in the next cycle. The offset map is 0x00 status, 0x02 enable, 0x04 control and 0x08 timer (zero-extended to 32 bits). Any other offset reads 0.
- R4: Only the status bits at positions 0 (timer), 5 (global lock), 8 (power button) and 10 (clock alarm) exist, and all other status bits read 0. A one-cycle high pulse on `evt_rtc_alarm`, `evt_pwr_btn` or `evt_glb_lock` sets bit 10, 8 or 5 at the next edge.
- R5: Writing a 1 to an existing status bit clears it, and writing a 0 leaves it unchanged. An event arriving in the same cycle as the clearing write wins, so the bit stays set.
- R6: The enable register (offset 0x02) and the control register (offset 0x04) are plain 16-bit read/write registers.
- R7: `sci` is high exactly when one of the four status bits is set together with the enable bit at the same position. It follows a register change in the same cycle that the register changes.
- R8: The timer counter advances by one on each cycle with `tmr_tick` high and holds otherwise. Writes to offset 0x08 have no effect.
- R9: A toggle of the timer counter's most significant bit sets timer status (bit 0) only while timer enable (enable bit 0) is 1 and timer status is 0.
- R10: Writes to offsets that hold no register (such as 0x06) change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_pm_base | input | 32 | Configuration value holding the window base (bits 15:6 used) |
| cfg_pm_ctrl | input | 8 | Configuration control byte; bit 0 enables decoding |
| io_addr | input | 16 | I/O byte address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 32 | Read data, valid with io_rvalid |
| io_rvalid | output | 1 | Read data valid, one cycle after a hitting read |
| evt_rtc_alarm | input | 1 | Clock alarm event pulse |
| evt_pwr_btn | input | 1 | Power button event pulse |
| evt_glb_lock | input | 1 | Global lock release event pulse |
| tmr_tick | input | 1 | Timer advance enable |
| sci | output | 1 | System control interrupt, level |

## Verification
On every cycle the assertions check the local cause-and-effect rules:
- the timer steps or holds with the tick;
- an event pulse sets its status bit;
- a one-written status bit clears when no event collides;
- timer status rises only with timer enable;
- read responses only follow read requests;
- the off state never answers.

Only the directed scenarios can show the behaviour seen at the ports: the offset map, the base masking and decode gating, the way `sci` combines enables with status, set-beats-clear ordering, and the armed and disarmed timer overflow after hundreds of ticks.

// File: rtl/pm1_pkg.sv
package pm1_pkg;

    typedef enum logic [1:0] {
        WIN_OFF   = 2'd0,
        WIN_IDLE  = 2'd1,
        WIN_RDATA = 2'd2
    } win_state_t;

    localparam logic [5:0] OFS_STS = 6'h00;
    localparam logic [5:0] OFS_EN  = 6'h02;
    localparam logic [5:0] OFS_CNT = 6'h04;
    localparam logic [5:0] OFS_TMR = 6'h08;

    localparam int BIT_TMR = 0;
    localparam int BIT_GLB = 5;
    localparam int BIT_PWR = 8;
    localparam int BIT_RTC = 10;

    localparam logic [15:0] STS_IMPL =
        (16'h1 << BIT_TMR) | (16'h1 << BIT_GLB) |
        (16'h1 << BIT_PWR) | (16'h1 << BIT_RTC);

    localparam logic [31:0] BASE_MASK = 32'h0000_FFC0;

endpackage

// File: rtl/pm1_timer.sv
module pm1_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [TMR_W-1:0] count,
    output logic             msb_toggle
);
    localparam int MSB = TMR_W - 1;

    logic [TMR_W-1:0] cnt_q;
    logic [TMR_W-1:0] cnt_inc;

    assign cnt_inc    = cnt_q + 1'b1;
    assign count      = cnt_q;
    assign msb_toggle = tick && (cnt_inc[MSB] != cnt_q[MSB]);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_inc;
        end
    end

    AST_TMR_STEP: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == $past(cnt_q) + 1'b1)); // R8
    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/pm1_evt_regs.sv
module pm1_evt_regs
    import pm1_pkg::*;
#(
    parameter int TMR_W = 24,
    parameter int RD_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stb,
    input  logic [5:0]       ofs,
    input  logic [15:0]      wdata,
    input  logic             evt_rtc,
    input  logic             evt_pwr,
    input  logic             evt_glb,
    input  logic             tmr_ovf,
    input  logic [TMR_W-1:0] tmr_val,
    output logic [RD_W-1:0]  rd_word,
    output logic             sci
);
    localparam int PAD_W = RD_W - TMR_W;

    logic [15:0] sts_q, en_q, cnt_q;
    logic [15:0] set_vec, clr_vec;
    logic        tmr_armed;

    assign tmr_armed = en_q[BIT_TMR] && !sts_q[BIT_TMR];

    always_comb begin
        set_vec          = '0;
        set_vec[BIT_RTC] = evt_rtc;
        set_vec[BIT_PWR] = evt_pwr;
        set_vec[BIT_GLB] = evt_glb;
        set_vec[BIT_TMR] = tmr_ovf && tmr_armed;
        clr_vec          = (wr_stb && ofs == OFS_STS) ? wdata : 16'h0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            en_q  <= '0;
            cnt_q <= '0;
        end else begin
            sts_q <= ((sts_q & ~clr_vec) | set_vec) & STS_IMPL;
            if (wr_stb && ofs == OFS_EN)  en_q  <= wdata;
            if (wr_stb && ofs == OFS_CNT) cnt_q <= wdata;
        end
    end

    assign sci = |(sts_q & en_q & STS_IMPL);

    always_comb begin
        unique case (ofs)
            OFS_STS: rd_word = {{(RD_W-16){1'b0}}, sts_q};
            OFS_EN:  rd_word = {{(RD_W-16){1'b0}}, en_q};
            OFS_CNT: rd_word = {{(RD_W-16){1'b0}}, cnt_q};
            OFS_TMR: rd_word = {{PAD_W{1'b0}}, tmr_val};
            default: rd_word = '0;
        endcase
    end

    AST_RTC_SETS: assert property (@(posedge clk) disable iff (rst)
        evt_rtc |=> sts_q[BIT_RTC]); // R4
    AST_W1C_GLB: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && ofs == OFS_STS && wdata[BIT_GLB] && !evt_glb) |=> !sts_q[BIT_GLB]); // R5
    AST_TMR_ARMED: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_q[BIT_TMR]) |-> $past(en_q[BIT_TMR])); // R9

endmodule

// File: rtl/pm1_win_dec.sv
module pm1_win_dec
    import pm1_pkg::*;
#(
    parameter int RD_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [31:0]     cfg_pm_base,
    input  logic [7:0]      cfg_pm_ctrl,
    input  logic [15:0]     io_addr,
    input  logic            io_wr,
    input  logic            io_rd,
    input  logic [RD_W-1:0] rd_word,
    output logic            wr_stb,
    output logic [5:0]      ofs,
    output logic [RD_W-1:0] io_rdata,
    output logic            io_rvalid
);
    win_state_t      state_q, state_d;
    logic            win_en, addr_hit, rd_hit;
    logic [RD_W-1:0] rdata_q;

    assign win_en   = (cfg_pm_ctrl & 8'h01) != 8'h00;
    assign addr_hit = (({16'h0, io_addr} & BASE_MASK) == (cfg_pm_base & BASE_MASK))
                      && (state_q != WIN_OFF);
    assign ofs      = io_addr[5:0];
    assign wr_stb   = addr_hit && io_wr;
    assign rd_hit   = addr_hit && io_rd;

    always_comb begin
        unique case (state_q)
            WIN_OFF:   state_d = win_en ? WIN_IDLE : WIN_OFF;
            WIN_IDLE,
            WIN_RDATA: begin
                if (!win_en)     state_d = WIN_OFF;
                else if (rd_hit) state_d = WIN_RDATA;
                else             state_d = WIN_IDLE;
            end
            default:   state_d = WIN_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WIN_OFF;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_hit) rdata_q <= rd_word;
        end
    end

    always_comb begin
        io_rvalid = 1'b0;
        io_rdata  = '0;
        unique case (state_q)
            WIN_RDATA: begin
                io_rvalid = 1'b1;
                io_rdata  = rdata_q;
            end
            WIN_OFF, WIN_IDLE: ;
            default: ;
        endcase
    end

    AST_RESP_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
        io_rvalid |-> $past(io_rd)); // R3
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        (state_q == WIN_OFF) |=> !io_rvalid); // R2

endmodule

// File: rtl/pm1_sci_top.sv
module pm1_sci_top #(
    parameter int TMR_W = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] cfg_pm_base,
    input  logic [7:0]  cfg_pm_ctrl,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [15:0] io_wdata,
    output logic [31:0] io_rdata,
    output logic        io_rvalid,
    input  logic        evt_rtc_alarm,
    input  logic        evt_pwr_btn,
    input  logic        evt_glb_lock,
    input  logic        tmr_tick,
    output logic        sci
);
    localparam int RD_W = 32;

    logic             wr_stb;
    logic [5:0]       ofs;
    logic [RD_W-1:0]  rd_word;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_ovf;

    pm1_win_dec #(.RD_W(RD_W)) u_dec (
        .clk(clk), .rst(rst),
        .cfg_pm_base(cfg_pm_base), .cfg_pm_ctrl(cfg_pm_ctrl),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .rd_word(rd_word), .wr_stb(wr_stb), .ofs(ofs),
        .io_rdata(io_rdata), .io_rvalid(io_rvalid)
    );

    pm1_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk(clk), .rst(rst), .tick(tmr_tick),
        .count(tmr_val), .msb_toggle(tmr_ovf)
    );

    pm1_evt_regs #(.TMR_W(TMR_W), .RD_W(RD_W)) u_regs (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .ofs(ofs), .wdata(io_wdata),
        .evt_rtc(evt_rtc_alarm), .evt_pwr(evt_pwr_btn), .evt_glb(evt_glb_lock),
        .tmr_ovf(tmr_ovf), .tmr_val(tmr_val), .rd_word(rd_word), .sci(sci)
    );

endmodule

// File: tb/pm1_sci_top_tb_top.sv
module pm1_sci_top_tb_top;
    localparam int TW = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] cfg_pm_base = 32'h0000_B03F;
    logic [7:0]  cfg_pm_ctrl = 8'h00;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [15:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        io_rvalid;
    logic        evt_rtc_alarm = 1'b0, evt_pwr_btn = 1'b0, evt_glb_lock = 1'b0;
    logic        tmr_tick = 1'b0;
    logic        sci;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5ns clk = ~clk;

    pm1_sci_top #(.TMR_W(TW)) dut_i (
        .clk(clk), .rst(rst), .cfg_pm_base(cfg_pm_base), .cfg_pm_ctrl(cfg_pm_ctrl),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_rvalid(io_rvalid),
        .evt_rtc_alarm(evt_rtc_alarm), .evt_pwr_btn(evt_pwr_btn),
        .evt_glb_lock(evt_glb_lock), .tmr_tick(tmr_tick), .sci(sci)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic v, output logic [31:0] d);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        v = io_rvalid; d = io_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
        logic v; logic [31:0] d;
        rd(a, v, d);
        check({req, " rvalid"}, {31'b0, v}, 32'h1);
        check(req, d, exp);
    endtask

    task automatic ticks(input int n);
        tmr_tick = 1'b1;
        repeat (n) @(negedge clk);
        tmr_tick = 1'b0;
    endtask

    task automatic t_reset_and_window;
        logic v; logic [31:0] d;
        check("R1 sci", {31'b0, sci}, 32'h0);
        rd(16'hB000, v, d);
        check("R2 off read", {31'b0, v}, 32'h0);
        wr(16'hB002, 16'h0400);
        cfg_pm_ctrl = 8'hFD;
        @(negedge clk);
        check("R2 no rvalid after enable edge", {31'b0, io_rvalid}, 32'h0);
        cfg_pm_ctrl = 8'h01;
        rd_chk("R1 status", 16'hB000, 32'h0);
        rd_chk("R1 enable", 16'hB002, 32'h0);
        rd_chk("R1 control", 16'hB004, 32'h0);
        rd_chk("R1 timer", 16'hB008, 32'h0);
        rd(16'hB040, v, d);
        check("R2 outside read", {31'b0, v}, 32'h0);
        wr(16'hB042, 16'hFFFF);
        rd_chk("R2 outside write", 16'hB002, 32'h0);
    endtask

    task automatic t_regs;
        wr(16'hB002, 16'hA5A4);
        rd_chk("R6 enable", 16'hB002, 32'h0000_A5A4);
        wr(16'hB004, 16'h1234);
        rd_chk("R6 control", 16'hB004, 32'h0000_1234);
        wr(16'hB006, 16'hFFFF);
        rd_chk("R10 hole write", 16'hB004, 32'h0000_1234);
        rd_chk("R10 hole read", 16'hB006, 32'h0);
        rd_chk("R3 unmapped", 16'hB00C, 32'h0);
        wr(16'hB008, 16'h0077);
        rd_chk("R8 timer write ignored", 16'hB008, 32'h0);
        check("R7 no status", {31'b0, sci}, 32'h0);
        wr(16'hB002, 16'h0000);
    endtask

    task automatic t_events;
        evt_rtc_alarm = 1'b1; @(negedge clk); evt_rtc_alarm = 1'b0;
        rd_chk("R4 rtc", 16'hB000, 32'h0000_0400);
        check("R7 masked", {31'b0, sci}, 32'h0);
        wr(16'hB002, 16'h0400);
        check("R7 enabled", {31'b0, sci}, 32'h1);
        wr(16'hB000, 16'h0400);
        check("R5 w1c drops sci", {31'b0, sci}, 32'h0);
        rd_chk("R5 cleared", 16'hB000, 32'h0);
        evt_pwr_btn = 1'b1; evt_glb_lock = 1'b1; @(negedge clk);
        evt_pwr_btn = 1'b0; evt_glb_lock = 1'b0;
        rd_chk("R4 pwr glb", 16'hB000, 32'h0000_0120);
        wr(16'hB000, 16'h0000);
        rd_chk("R5 zero write", 16'hB000, 32'h0000_0120);
        io_addr = 16'hB000; io_wdata = 16'h0120; io_wr = 1'b1; evt_glb_lock = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; evt_glb_lock = 1'b0;
        rd_chk("R5 set beats clear", 16'hB000, 32'h0000_0020);
        wr(16'hB002, 16'h0020);
        check("R7 glb sci", {31'b0, sci}, 32'h1);
        wr(16'hB002, 16'h0000);
        check("R7 enable clear drops sci", {31'b0, sci}, 32'h0);
        wr(16'hB000, 16'hFFFF);
        rd_chk("R4 unimplemented bits", 16'hB000, 32'h0);
    endtask

    task automatic t_timer;
        ticks(5);
        rd_chk("R8 count", 16'hB008, 32'd5);
        ticks(600);
        rd_chk("R8 count 605", 16'hB008, 32'd605);
        rd_chk("R9 disarmed", 16'hB000, 32'h0);
        wr(16'hB002, 16'h0001);
        ticks(420);
        rd_chk("R8 wrap", 16'hB008, 32'd1);
        rd_chk("R9 armed", 16'hB000, 32'h0000_0001);
        check("R7 timer sci", {31'b0, sci}, 32'h1);
        wr(16'hB000, 16'h0001);
        check("R9 cleared", {31'b0, sci}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_and_window();
        t_regs();
        t_events();
        t_timer();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #500us;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule